// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks which page frame to evict when a page fault needs a free frame. It approximates least-recently-used replacement. It keeps one reference bit per frame and walks a pointer round the frames, which form a ring. An access or a completed page load sets the bit of its frame. When a fault request arrives, the sweep examines one frame per clock. A frame whose bit is set loses that bit and is passed over. The first frame found with its bit already clear becomes the victim. The pointer then rests on the frame after the victim.

Two run-time modes change how bits are cleared. In reference-clear mode, each access that arrives while the block is idle also clears the bit under the clearing hand and moves the pointer on by one, so the ring ages without waiting for a fault. In two-hand mode, a leading hand a fixed number of frames ahead does the clearing. The trailing hand only tests bits and chooses the victim. This shortens the time a frame has to prove it is still in use. Disk transfers and page table updates belong to the surrounding system. The block only reports the chosen index with a one-cycle done pulse.

Top module: `clock_victim_sel`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `victim_valid` are 0, `victim_frame` is 0, every reference bit is clear and the hand points at frame 0.
- R2: `acc_valid` or `load_valid` sets the reference bit of the named frame at the next edge. When a clear and a set hit the same frame on one edge, the bit ends set.
- R3: In single-hand mode (`two_hand_mode`=0), each busy cycle examines the frame under the hand. If its bit is set, the bit is cleared and the hand moves on by one. If the bit is clear, that frame is the victim.
- R4: The victim is reported by `victim_valid` high for exactly one cycle, together with `victim_frame`, on the same edge at which `busy` falls. The hand then rests on the victim index plus one, modulo NFRAMES.
- R5: In single-hand mode with every bit set, the sweep lasts NFRAMES+1 busy cycles and selects the frame where it started. No bits are left set afterwards.
- R6: With `ref_clear_mode`=1, an access while idle and without a fault request clears the bit under the clearing hand and advances the hand by one. The clearing hand is the hand itself in single-hand mode, and the leading hand in two-hand mode. With the mode off, the hand moves only during a sweep.
- R7: In two-hand mode, each busy cycle clears the bit at the leading hand, which is the trailing hand plus HAND_GAP, modulo NFRAMES. It examines the trailing hand's frame without clearing it, and the first frame found clear there is the victim.
- R8: In two-hand mode with every bit set, the sweep lasts HAND_GAP+1 busy cycles and selects the start frame plus HAND_GAP, modulo NFRAMES.
- R9: A fault request while idle raises `busy` at the next edge. `busy` stays high until the victim is reported, and fault requests seen while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Page access strobe |
| acc_frame | input | IDXW | Frame index of the access |
| load_valid | input | 1 | Page load complete strobe |
| load_frame | input | IDXW | Frame index just loaded |
| fault_req | input | 1 | Request for a victim frame |
| ref_clear_mode | input | 1 | Clear one frame per reference while idle |
| two_hand_mode | input | 1 | Use leading clearing hand and trailing selecting hand |
| busy | output | 1 | Sweep in progress |
| victim_valid | output | 1 | One-cycle done pulse |
| victim_frame | output | IDXW | Index of the chosen victim |

## Verification
The hardest situation to reach from the ports is a clear and a set landing on the same frame on the same edge, because the hand position is never visible. The stimulus uses reference-clear mode and aims an access at the frame known to be under the hand. It then fills every other bit and issues a fault. The sweep length and victim differ by one frame depending on whether the set won. Long all-set sweeps in both hand modes are reached by touching every frame before the fault. A behavioural model checked on every cycle covers the intervening hand positions.

// File: rtl/clock_victim_pkg.sv
// Shared types for the clock victim selector.
package clock_victim_pkg;
    // Sweep controller state.
    typedef enum logic {
        SW_IDLE  = 1'b0,
        SW_SWEEP = 1'b1
    } sweep_state_t;
endpackage

// File: rtl/clock_ref_bits.sv
// Reference-bit ring: one bit per frame.
// Assumes: at most one clear per cycle. Sets from access and load win over a
// clear aimed at the same frame on the same edge.
module clock_ref_bits #(
    parameter int NFRAMES = 8,
    parameter int IDXW    = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_a_en,
    input  logic [IDXW-1:0]    set_a_idx,
    input  logic               set_b_en,
    input  logic [IDXW-1:0]    set_b_idx,
    input  logic               clr_en,
    input  logic [IDXW-1:0]    clr_idx,
    output logic [NFRAMES-1:0] bits
);
    for (genvar i = 0; i < NFRAMES; i++) begin : g_frame
        logic hit_clr, hit_set;
        // Decode whether this frame is cleared or set this cycle.
        always_comb begin
            hit_clr = clr_en && (clr_idx == IDXW'(i));
            hit_set = (set_a_en && (set_a_idx == IDXW'(i))) ||
                      (set_b_en && (set_b_idx == IDXW'(i)));
        end
        // Hold the bit of this frame; set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits[i] <= 1'b0;
            else if (hit_set)
                bits[i] <= 1'b1;
            else if (hit_clr)
                bits[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/clock_hand.sv
// Hand pointer: the trailing (examining) hand and a leading hand derived from
// it at a fixed distance. Assumes 1 <= HAND_GAP < NFRAMES.
module clock_hand #(
    parameter int NFRAMES  = 8,
    parameter int HAND_GAP = 3,
    parameter int IDXW     = $clog2(NFRAMES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [IDXW-1:0] hand,
    output logic [IDXW-1:0] lead
);
    localparam logic [IDXW:0]   GAP_W  = (IDXW+1)'(HAND_GAP);
    localparam logic [IDXW:0]   N_W    = (IDXW+1)'(NFRAMES);
    localparam logic [IDXW-1:0] LAST_W = IDXW'(NFRAMES - 1);

    logic [IDXW:0] lead_sum;

    // Advance the hand by one frame, wrapping at the end of the ring.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hand <= '0;
        else if (adv)
            hand <= (hand == LAST_W) ? '0 : hand + 1'b1;
    end

    // Leading hand is the hand plus the gap, modulo the ring size.
    always_comb begin
        lead_sum = {1'b0, hand} + GAP_W;
        lead     = (lead_sum >= N_W) ? IDXW'(lead_sum - N_W) : lead_sum[IDXW-1:0];
    end
endmodule

// File: rtl/clock_sweep_ctrl.sv
// Sweep controller: accepts fault requests, steps the hand one frame per
// cycle, directs the bit clears and reports the victim.
// Assumes mode inputs are held steady while a sweep runs.
module clock_sweep_ctrl
    import clock_victim_pkg::*;
#(
    parameter int NFRAMES = 8,
    parameter int IDXW    = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fault_req,
    input  logic               acc_valid,
    input  logic               ref_clear_mode,
    input  logic               two_hand_mode,
    input  logic [NFRAMES-1:0] bits,
    input  logic [IDXW-1:0]    hand,
    input  logic [IDXW-1:0]    lead,
    output logic               clr_en,
    output logic [IDXW-1:0]    clr_idx,
    output logic               hand_adv,
    output logic               busy,
    output logic               victim_valid,
    output logic [IDXW-1:0]    victim_frame
);
    sweep_state_t state;
    logic         found;
    logic [IDXW-1:0] clear_hand;

    // Pick the clearing hand and decide clears and hand steps for this cycle.
    always_comb begin
        clear_hand = two_hand_mode ? lead : hand;
        found      = 1'b0;
        clr_en     = 1'b0;
        hand_adv   = 1'b0;
        clr_idx    = clear_hand;
        if (state == SW_SWEEP) begin
            clr_en   = 1'b1;
            hand_adv = 1'b1;
            found    = !bits[hand];
        end else if (!fault_req && ref_clear_mode && acc_valid) begin
            clr_en   = 1'b1;
            hand_adv = 1'b1;
        end
    end

    // Track sweep state and register the victim report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= SW_IDLE;
            victim_valid <= 1'b0;
            victim_frame <= '0;
        end else begin
            victim_valid <= 1'b0;
            case (state)
                SW_IDLE: if (fault_req) state <= SW_SWEEP;
                SW_SWEEP: if (found) begin
                    state        <= SW_IDLE;
                    victim_valid <= 1'b1;
                    victim_frame <= hand;
                end
                default: state <= SW_IDLE;
            endcase
        end
    end

    assign busy = (state == SW_SWEEP);
endmodule

// File: rtl/clock_victim_sel.sv
// Clock second-chance victim selector top. Joins the reference-bit ring,
// the hand pointer and the sweep controller.
// Assumes NFRAMES is a power of two so every index value names a frame.
module clock_victim_sel #(
    parameter int NFRAMES  = 8,
    parameter int HAND_GAP = 3,
    parameter int IDXW     = $clog2(NFRAMES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [IDXW-1:0] acc_frame,
    input  logic            load_valid,
    input  logic [IDXW-1:0] load_frame,
    input  logic            fault_req,
    input  logic            ref_clear_mode,
    input  logic            two_hand_mode,
    output logic            busy,
    output logic            victim_valid,
    output logic [IDXW-1:0] victim_frame
);
    logic [NFRAMES-1:0] ref_bits;
    logic [IDXW-1:0]    hand_q, lead_q, clr_idx;
    logic               clr_en, hand_adv;

    clock_ref_bits #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_bits (
        .clk(clk), .rst_n(rst_n),
        .set_a_en(acc_valid), .set_a_idx(acc_frame),
        .set_b_en(load_valid), .set_b_idx(load_frame),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .bits(ref_bits)
    );

    clock_hand #(.NFRAMES(NFRAMES), .HAND_GAP(HAND_GAP), .IDXW(IDXW)) u_hand (
        .clk(clk), .rst_n(rst_n), .adv(hand_adv),
        .hand(hand_q), .lead(lead_q)
    );

    clock_sweep_ctrl #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fault_req(fault_req), .acc_valid(acc_valid),
        .ref_clear_mode(ref_clear_mode), .two_hand_mode(two_hand_mode),
        .bits(ref_bits), .hand(hand_q), .lead(lead_q),
        .clr_en(clr_en), .clr_idx(clr_idx), .hand_adv(hand_adv),
        .busy(busy), .victim_valid(victim_valid), .victim_frame(victim_frame)
    );
endmodule

// File: rtl/clock_victim_sel_chk.sv
// Property checker for clock_victim_sel, attached by bind.
module clock_victim_sel_chk #(
    parameter int NFRAMES = 8,
    parameter int IDXW    = $clog2(NFRAMES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fault_req,
    input logic               acc_valid,
    input logic [IDXW-1:0]    acc_frame,
    input logic               ref_clear_mode,
    input logic               busy,
    input logic               victim_valid,
    input logic [IDXW-1:0]    victim_frame,
    input logic [IDXW-1:0]    hand,
    input logic [NFRAMES-1:0] ref_bits
);
    localparam logic [IDXW-1:0] LAST_W = IDXW'(NFRAMES - 1);
    logic [IDXW-1:0] after_victim, after_hand;
    logic            idle_step;

    // Expected positions one frame past the victim and past the hand.
    always_comb begin
        after_victim = (victim_frame == LAST_W) ? '0 : victim_frame + 1'b1;
        after_hand   = (hand == LAST_W) ? '0 : hand + 1'b1;
        idle_step    = !busy && !fault_req && ref_clear_mode && acc_valid;
    end

    // R2: an access leaves its frame's bit set
    a_r2_access_sets: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ref_bits[$past(acc_frame)]);
    // R4: done is a single-cycle pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |=> !victim_valid);
    // R4: done coincides with the fall of busy
    a_r4_done_with_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> $fell(busy));
    // R4: hand rests one past the victim
    a_r4_hand_past_victim: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (hand == after_victim));
    // R9: an idle fault starts a sweep
    a_r9_fault_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fault_req) |=> busy);
    // R9: busy holds until the victim is reported
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || victim_valid));
    // R6: idle hand stays put unless a reference-clear step occurs
    a_r6_idle_hand_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !idle_step) |=> $stable(hand));
    // R6: a reference-clear step moves the hand by one
    a_r6_ref_step: assert property (@(posedge clk) disable iff (!rst_n)
        idle_step |=> (hand == $past(after_hand)));
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fault_req(fault_req),
    .acc_valid(acc_valid), .acc_frame(acc_frame),
    .ref_clear_mode(ref_clear_mode), .busy(busy),
    .victim_valid(victim_valid), .victim_frame(victim_frame),
    .hand(hand_q), .ref_bits(ref_bits)
);

// File: tb/clock_victim_sel_tb.sv
`timescale 1ns/1ps
// Bench for clock_victim_sel: behavioural model compared every cycle plus
// directed sweeps with hand-computed victims and sweep lengths.
module clock_victim_sel_tb;
    localparam int N    = 8;
    localparam int GAP  = 3;
    localparam int IDXW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, load_valid = 1'b0, fault_req = 1'b0;
    logic ref_clear_mode = 1'b0, two_hand_mode = 1'b0;
    logic [IDXW-1:0] acc_frame = '0, load_frame = '0;
    logic busy, victim_valid;
    logic [IDXW-1:0] victim_frame;

    int errors = 0;
    int checks = 0;
    bit model_on = 1'b0;

    // Behavioural model state
    bit m_bits[N];
    int m_hand = 0;
    bit m_busy = 1'b0, m_vv = 1'b0;
    int m_vi = 0;

    always #2.5 clk = ~clk;

    clock_victim_sel #(.NFRAMES(N), .HAND_GAP(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_frame(acc_frame),
        .load_valid(load_valid), .load_frame(load_frame),
        .fault_req(fault_req), .ref_clear_mode(ref_clear_mode),
        .two_hand_mode(two_hand_mode),
        .busy(busy), .victim_valid(victim_valid), .victim_frame(victim_frame)
    );

    task automatic check(input bit ok, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    // Model update at each edge from the inputs held since the last falling edge.
    always @(posedge clk) begin
        bit nb[N];
        int lead, nh, chand;
        bit nbusy, nvv;
        int nvi;
        if (!rst_n) begin
            foreach (m_bits[i]) m_bits[i] = 1'b0;
            m_hand = 0; m_busy = 1'b0; m_vv = 1'b0; m_vi = 0;
        end else begin
            nb = m_bits; nh = m_hand; nbusy = m_busy; nvv = 1'b0; nvi = m_vi;
            lead  = (m_hand + GAP) % N;
            chand = two_hand_mode ? lead : m_hand;
            if (m_busy) begin
                nb[chand] = 1'b0;
                if (!m_bits[m_hand]) begin
                    nvv = 1'b1; nvi = m_hand; nbusy = 1'b0;
                end
                nh = (m_hand + 1) % N;
            end else if (fault_req) begin
                nbusy = 1'b1;
            end else if (ref_clear_mode && acc_valid) begin
                nb[chand] = 1'b0;
                nh = (m_hand + 1) % N;
            end
            if (acc_valid)  nb[acc_frame]  = 1'b1;
            if (load_valid) nb[load_frame] = 1'b1;
            m_bits = nb; m_hand = nh; m_busy = nbusy; m_vv = nvv; m_vi = nvi;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_on) begin
            check(busy == m_busy, "R9 busy vs model", int'(busy), int'(m_busy));
            check(victim_valid == m_vv, "R4 victim_valid vs model", int'(victim_valid), int'(m_vv));
            check(int'(victim_frame) == m_vi, "R3 victim_frame vs model", int'(victim_frame), m_vi);
        end
    end

    task automatic touch(input int f);
        acc_valid = 1'b1; acc_frame = IDXW'(f);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic load(input int f);
        load_valid = 1'b1; load_frame = IDXW'(f);
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic touch_all();
        for (int f = 0; f < N; f++) touch(f);
    endtask

    // Issue a fault, hold the request for 'hold' cycles, then check victim and sweep length.
    task automatic fault(input int exp_v, input int exp_len, input int hold, input string tag);
        int cnt = 0;
        int cyc = 0;
        fault_req = 1'b1;
        @(negedge clk);
        cyc = 1;
        while (!victim_valid && cyc < 100) begin
            if (busy) cnt++;
            if (cyc >= hold) fault_req = 1'b0;
            @(negedge clk);
            cyc++;
        end
        fault_req = 1'b0;
        check(victim_valid == 1'b1, {tag, " victim reported"}, int'(victim_valid), 1);
        check(int'(victim_frame) == exp_v, {tag, " victim index"}, int'(victim_frame), exp_v);
        check(cnt == exp_len, {tag, " busy cycles"}, cnt, exp_len);
        check(busy == 1'b0, "R4 busy low with done", int'(busy), 0);
        @(negedge clk);
        check(victim_valid == 1'b0, "R4 done lasts one cycle", int'(victim_valid), 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(20000 * 5);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(victim_valid == 1'b0, "R1 victim_valid after reset", int'(victim_valid), 0);
        check(victim_frame == '0, "R1 victim_frame after reset", int'(victim_frame), 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);

        // R1/R3: all bits clear, hand at 0 -> frame 0 in one step
        fault(0, 1, 1, "R1 R3 first fault");
        // R2/R3: frames 1 and 2 referenced, one by load -> skip both, victim 3
        touch(1);
        load(2);
        fault(3, 3, 1, "R2 R3 skip referenced");
        // R5/R9: all set, request held while busy -> N+1 steps, start frame 4
        touch_all();
        fault(4, N + 1, 3, "R5 R9 full revolution");
        // R5: no bits left set -> next frame 5 at once
        fault(5, 1, 1, "R5 bits cleared after revolution");
        // R6: all set, one reference-clear step clears frame 6, hand to 7
        touch_all();
        ref_clear_mode = 1'b1;
        touch(0);
        ref_clear_mode = 1'b0;
        fault(6, 8, 1, "R6 reference clear step");
        // R8: two hands, all set, start 7 -> victim 2 after GAP+1 steps
        touch_all();
        two_hand_mode = 1'b1;
        fault(2, GAP + 1, 1, "R8 two-hand full set");
        // R7: lead cleared frame 3 earlier, trailing hand picks it at once
        fault(3, 1, 1, "R7 trailing hand selects");
        two_hand_mode = 1'b0;
        // R2: clear and set on frame 4 together -> bit stays set
        ref_clear_mode = 1'b1;
        touch(4);
        ref_clear_mode = 1'b0;
        for (int f = 5; f < 5 + 7; f++) touch(f % N);
        fault(5, N + 1, 1, "R2 set wins over clear");
        // R6/R7: two-hand reference-clear clears lead frame 1
        touch_all();
        two_hand_mode = 1'b1;
        ref_clear_mode = 1'b1;
        touch(0);
        ref_clear_mode = 1'b0;
        fault(1, 3, 1, "R6 R7 lead hand reference clear");
        two_hand_mode = 1'b0;

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule